// File: doc/BRIEF.md
# Indirect Interrupt-Routing Register Window

This block is the software-facing register front end of an interrupt routing controller. Software sees only three dword registers inside a 4 KB window: an 8-bit index register, a 32-bit data register and a write-only end-of-interrupt register. Writing the index register picks one internal register. A later read or write of the data register then reaches that internal register. The internal space holds a writable identification register, a constant version register and a table of 64-bit redirection entries. Each entry is reached as two consecutive dword indices.

The upper address bits that place the window are split into two parts. The top part is fixed by a parameter. The bits just above the 4 KB offset come from a configuration input, so the window can be moved at run time. A write to the end-of-interrupt register produces a one-cycle strobe that carries a vector number. Accesses are whole dwords only: the bus carries no byte enables, and the block does not merge or repair partial accesses.

Top module: `irw_top`

## Requirements
- R1: After a cycle with `rst_n` low, the following hold: the index register is 00h, the identification register is 0, every redirection low dword is 0x0001_0000 (mask bit 16 set), every high dword is 0, `bus_rdata` is 0 and `eoi_pulse` is 0.
- R2: The window responds only when `bus_addr[31:20]` equals 0xFEC and `bus_addr[19:12]` equals `cfg_base`. For any other address, writes change no register and a read returns 0.
- R3: The index register sits at window offset 000h. A write stores `bus_wdata[7:0]`. A read returns the stored value zero-extended to 32 bits.
- R4: The data register sits at offset 010h and reaches the internal register selected by the current index. Index 00h is the identification register: a full 32-bit register that reads back what was written.
- R5: Index 01h is the version register. It reads 0x0017_0020: bits 23:16 hold the highest entry number (23), bits 7:0 hold version code 20h, and all other bits are 0. Writes to it are ignored.
- R6: Redirection entry n (n = 0..23) has its low dword at index 10h+2n and its high dword at index 11h+2n. Each dword reads back what was last written to it, and a write to one dword leaves every other dword unchanged.
- R7: Bits 12 and 14 of every low dword are read-only. They always read 0, and writes to them are ignored.
- R8: Indices 02h..0Fh and 40h..FFh are reserved. They read as 0, and writes to them are ignored.
- R9: A write to offset 040h makes `eoi_pulse` high for exactly the following cycle, with `eoi_vector` equal to `bus_wdata[7:0]` of that write. A read of offset 040h returns 0.
- R10: `bus_rdata` is registered. It carries the read result in the cycle after `bus_rd` is high, and it is 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 8 | Programmable window base bits, compared with address bits 19:12 |
| bus_addr | input | 32 | Byte address of the dword access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_vector | output | 8 | Vector number carried with the strobe |

## Verification
The bench builds the block with its default parameters: 24 entries, version code 20h, fixed upper address bits FECh and an 8-bit programmable base. With 24 entries, the index space reaches the last high dword at 3Fh. The bench can therefore hit both edges of the table and the reserved indices just beside them, 0Fh-side and 40h. It also moves `cfg_base` at run time, to show that the window follows the base and that the old base stops decoding.

// File: rtl/irw_pkg.sv
// Package: shared constants and types for the indirect register window.
// Assumes dword-aligned accesses; window offsets are byte offsets in a 4 KB page.
package irw_pkg;

    localparam int unsigned PAGE_BITS = 12;

    localparam logic [PAGE_BITS-1:0] OFF_INDEX = 12'h000;
    localparam logic [PAGE_BITS-1:0] OFF_DATA  = 12'h010;
    localparam logic [PAGE_BITS-1:0] OFF_EOI   = 12'h040;

    localparam logic [7:0] IDX_IDENT   = 8'h00;
    localparam logic [7:0] IDX_VERSION = 8'h01;
    localparam logic [7:0] IDX_TABLE   = 8'h10;

    // Low-dword bits that software cannot set (status positions)
    localparam logic [31:0] LO_RO_MASK  = 32'h0000_5000;
    localparam logic [31:0] LO_RESET    = 32'h0001_0000;
    localparam logic [31:0] HI_RESET    = 32'h0000_0000;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_INDEX = 2'd1,
        WIN_DATA  = 2'd2,
        WIN_EOI   = 2'd3
    } win_sel_e;

endpackage

// File: rtl/irw_decode.sv
// Module: address decoder for the window.
// Compares the upper address against a fixed prefix and the programmable base,
// then resolves the page offset to one of the three direct registers.
// Assumes: pure combinational; bus strobes are single-cycle.
module irw_decode
    import irw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BASE_W   = 8,
    parameter int unsigned HI_W     = ADDR_W - PAGE_BITS - BASE_W,
    parameter logic [HI_W-1:0] FIXED_HI = 12'hFEC
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_index,
    output logic              wr_data,
    output logic              wr_eoi,
    output logic              rd_valid,
    output win_sel_e          sel
);

    logic page_hit;

    // Page match: fixed prefix and programmable base must both agree
    always_comb begin
        page_hit = (addr[ADDR_W-1 -: HI_W] == FIXED_HI) &&
                   (addr[PAGE_BITS +: BASE_W] == cfg_base);
    end

    // Offset decode into a register selector
    always_comb begin
        sel = WIN_NONE;
        if (page_hit) begin
            unique case (addr[PAGE_BITS-1:0])
                OFF_INDEX: sel = WIN_INDEX;
                OFF_DATA:  sel = WIN_DATA;
                OFF_EOI:   sel = WIN_EOI;
                default:   sel = WIN_NONE;
            endcase
        end
    end

    // Qualified strobes toward the storage and strobe logic
    always_comb begin
        wr_index = wr && (sel == WIN_INDEX);
        wr_data  = wr && (sel == WIN_DATA);
        wr_eoi   = wr && (sel == WIN_EOI);
        rd_valid = rd;
    end

endmodule

// File: rtl/irw_redir_table.sv
// Module: storage for the redirection entries, two dwords each.
// Entry n low dword lives at index TABLE_BASE+2n, high dword at +2n+1.
// Assumes: the caller presents an 8-bit index; out-of-table indices are
// reported through in_table and never written.
module irw_redir_table
    import irw_pkg::*;
#(
    parameter int unsigned NUM_ENT = 24,
    parameter int unsigned ENT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  idx,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic        in_table,
    output logic [31:0] rdata
);

    localparam int unsigned SPAN = 2 * NUM_ENT;

    logic [31:0]      lo_q [NUM_ENT];
    logic [31:0]      hi_q [NUM_ENT];
    logic [7:0]       rel;
    logic [ENT_W-1:0] ent;

    // Relative index and table range check
    always_comb begin
        rel      = idx - IDX_TABLE;
        in_table = (idx >= IDX_TABLE) && ({24'd0, rel} < SPAN);
        ent      = rel[ENT_W:1];
    end

    // One register pair per entry
    for (genvar n = 0; n < NUM_ENT; n++) begin : g_ent
        localparam logic [7:0] LO_IDX = 8'(IDX_TABLE + 2 * n);
        localparam logic [7:0] HI_IDX = 8'(IDX_TABLE + 2 * n + 1);

        // Low dword: read-only status bits are kept at zero
        always_ff @(posedge clk) begin
            if (!rst_n)
                lo_q[n] <= LO_RESET;
            else if (we && idx == LO_IDX)
                lo_q[n] <= wdata & ~LO_RO_MASK;
        end

        // High dword: fully writable
        always_ff @(posedge clk) begin
            if (!rst_n)
                hi_q[n] <= HI_RESET;
            else if (we && idx == HI_IDX)
                hi_q[n] <= wdata;
        end

        AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && idx == LO_IDX) |=> $stable(lo_q[n])) else $error("lo dword changed"); // R6
        AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && idx == HI_IDX) |=> $stable(hi_q[n])) else $error("hi dword changed"); // R6
    end

    // Read mux: select entry, then dword half
    always_comb begin
        rdata = 32'd0;
        if (in_table)
            rdata = rel[0] ? hi_q[ent] : lo_q[ent];
    end

endmodule

// File: rtl/irw_indirect_regs.sv
// Module: index register plus the indirectly reached register space.
// Holds the index, the identification register, the constant version value
// and the redirection table; returns the dword picked by the current index.
// Assumes: reserved indices read zero and drop writes.
module irw_indirect_regs
    import irw_pkg::*;
#(
    parameter int unsigned NUM_ENT  = 24,
    parameter logic [7:0]  VER_CODE = 8'h20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_index,
    input  logic        wr_data,
    input  logic [31:0] wdata,
    output logic [7:0]  index_q,
    output logic [31:0] data_rd
);

    localparam logic [31:0] VER_VALUE = {8'h00, 8'(NUM_ENT - 1), 8'h00, VER_CODE};

    logic [31:0] ident_q;
    logic        tbl_hit;
    logic [31:0] tbl_rdata;
    logic        tbl_we;

    // Index register: low byte of the write data
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= 8'h00;
        else if (wr_index)
            index_q <= wdata[7:0];
    end

    // Identification register: full dword read/write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ident_q <= 32'd0;
        else if (wr_data && index_q == IDX_IDENT)
            ident_q <= wdata;
    end

    // Table write enable: only when the index lands inside the table
    always_comb begin
        tbl_we = wr_data && tbl_hit;
    end

    irw_redir_table #(
        .NUM_ENT (NUM_ENT)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (index_q),
        .we       (tbl_we),
        .wdata    (wdata),
        .in_table (tbl_hit),
        .rdata    (tbl_rdata)
    );

    // Data read mux over identification, version, table and reserved
    always_comb begin
        if (index_q == IDX_IDENT)
            data_rd = ident_q;
        else if (index_q == IDX_VERSION)
            data_rd = VER_VALUE;
        else if (tbl_hit)
            data_rd = tbl_rdata;
        else
            data_rd = 32'd0;
    end

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_index |=> $stable(index_q)) else $error("index moved"); // R3
    AST_IDENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data && index_q == IDX_IDENT) |=> $stable(ident_q)) else $error("ident moved"); // R4

endmodule

// File: rtl/irw_eoi.sv
// Module: end-of-interrupt strobe generator.
// Registers a one-cycle pulse and its vector from a decoded EOI write.
// Assumes: vector is meaningful only while the pulse is high.
module irw_eoi (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_eoi,
    input  logic [7:0] vec_in,
    output logic       pulse,
    output logic [7:0] vector
);

    // Pulse and vector capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            vector <= 8'h00;
        end else begin
            pulse <= wr_eoi;
            if (wr_eoi)
                vector <= vec_in;
        end
    end

endmodule

// File: rtl/irw_top.sv
// Module: top of the indirect interrupt-routing register window.
// Decodes the window, routes writes to the index/data/EOI targets and
// registers read data one cycle after the read strobe.
// Assumes: dword-only accesses, no simultaneous read and write.
module irw_top
    import irw_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BASE_W   = 8,
    parameter int unsigned NUM_ENT  = 24,
    parameter logic [7:0]  VER_CODE = 8'h20,
    parameter logic [ADDR_W-PAGE_BITS-BASE_W-1:0] FIXED_HI = 12'hFEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eoi_pulse,
    output logic [7:0]        eoi_vector
);

    localparam int unsigned HI_W = ADDR_W - PAGE_BITS - BASE_W;

    logic        wr_index;
    logic        wr_data;
    logic        wr_eoi;
    logic        rd_valid;
    win_sel_e    sel;
    logic [7:0]  index_q;
    logic [31:0] data_rd;
    logic [31:0] rd_mux;

    irw_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_W   (BASE_W),
        .HI_W     (HI_W),
        .FIXED_HI (FIXED_HI)
    ) u_decode (
        .addr     (bus_addr),
        .cfg_base (cfg_base),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wr_index (wr_index),
        .wr_data  (wr_data),
        .wr_eoi   (wr_eoi),
        .rd_valid (rd_valid),
        .sel      (sel)
    );

    irw_indirect_regs #(
        .NUM_ENT  (NUM_ENT),
        .VER_CODE (VER_CODE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_index (wr_index),
        .wr_data  (wr_data),
        .wdata    (bus_wdata),
        .index_q  (index_q),
        .data_rd  (data_rd)
    );

    irw_eoi u_eoi (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_eoi (wr_eoi),
        .vec_in (bus_wdata[7:0]),
        .pulse  (eoi_pulse),
        .vector (eoi_vector)
    );

    // Read source selection by window register
    always_comb begin
        unique case (sel)
            WIN_INDEX: rd_mux = {24'd0, index_q};
            WIN_DATA:  rd_mux = data_rd;
            default:   rd_mux = 32'd0;
        endcase
    end

    // Registered read data, zero when no read was issued
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 32'd0;
        else
            bus_rdata <= rd_valid ? rd_mux : 32'd0;
    end

    AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> $past(bus_wr && bus_addr[PAGE_BITS-1:0] == OFF_EOI)) else $error("stray eoi"); // R9
    AST_EOI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> eoi_vector == $past(bus_wdata[7:0])) else $error("eoi vector"); // R9
    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr[PAGE_BITS +: BASE_W] != cfg_base) |-> bus_rdata == 32'd0)
        else $error("miss read nonzero"); // R2
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'd0) else $error("idle rdata"); // R10

endmodule

// File: tb/tb_irw_top.sv
`timescale 1ns/1ps
module tb_irw_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_base = 8'h3A;
    logic [31:0] bus_addr = 32'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        eoi_pulse;
    logic [7:0]  eoi_vector;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    irw_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_base   (cfg_base),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .eoi_pulse  (eoi_pulse),
        .eoi_vector (eoi_vector)
    );

    typedef struct packed {
        logic        rd;
        logic [11:0] off;
        logic [31:0] val;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0000_0000, "R3 "},
        '{1'b0, 12'h010, 32'h1234_5678, "R4 "},
        '{1'b1, 12'h010, 32'h1234_5678, "R4 "},
        '{1'b1, 12'h000, 32'h0000_0000, "R3 "},
        '{1'b0, 12'h000, 32'h0000_0001, "R5 "},
        '{1'b1, 12'h010, 32'h0017_0020, "R5 "},
        '{1'b0, 12'h010, 32'hFFFF_FFFF, "R5 "},
        '{1'b1, 12'h010, 32'h0017_0020, "R5 "},
        '{1'b0, 12'h000, 32'h0000_0010, "R6 "},
        '{1'b1, 12'h010, 32'h0001_0000, "R1 "},
        '{1'b0, 12'h010, 32'hFFFF_FFFF, "R7 "},
        '{1'b1, 12'h010, 32'hFFFF_AFFF, "R7 "},
        '{1'b0, 12'h000, 32'h0000_0011, "R6 "},
        '{1'b1, 12'h010, 32'h0000_0000, "R1 "},
        '{1'b0, 12'h010, 32'hCAFE_F00D, "R6 "},
        '{1'b1, 12'h010, 32'hCAFE_F00D, "R6 "},
        '{1'b0, 12'h000, 32'h0000_003E, "R6 "},
        '{1'b0, 12'h010, 32'h0000_5000, "R7 "},
        '{1'b1, 12'h010, 32'h0000_0000, "R7 "},
        '{1'b0, 12'h000, 32'h0000_003F, "R6 "},
        '{1'b0, 12'h010, 32'hA5A5_A5A5, "R6 "},
        '{1'b1, 12'h010, 32'hA5A5_A5A5, "R6 "},
        '{1'b0, 12'h000, 32'h0000_0005, "R8 "},
        '{1'b0, 12'h010, 32'hDEAD_BEEF, "R8 "},
        '{1'b1, 12'h010, 32'h0000_0000, "R8 "},
        '{1'b0, 12'h000, 32'h0000_0040, "R8 "},
        '{1'b0, 12'h010, 32'hDEAD_BEEF, "R8 "},
        '{1'b1, 12'h010, 32'h0000_0000, "R8 "},
        '{1'b0, 12'h000, 32'h0000_00FF, "R8 "},
        '{1'b1, 12'h010, 32'h0000_0000, "R8 "},
        '{1'b1, 12'h000, 32'h0000_00FF, "R3 "},
        '{1'b1, 12'h040, 32'h0000_0000, "R9 "},
        '{1'b0, 12'h000, 32'h0000_0010, "R6 "},
        '{1'b1, 12'h010, 32'hFFFF_AFFF, "R6 "},
        '{1'b0, 12'h000, 32'hABCD_EF12, "R3 "},
        '{1'b1, 12'h000, 32'h0000_0012, "R3 "}
    };

    function automatic logic [31:0] win(input logic [11:0] off);
        return {12'hFEC, cfg_base, off};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    // Drive a write for one cycle (inputs change on the falling edge)
    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Issue a read; result is registered and sampled at the next falling edge
    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", bus_rdata, 32'd0);
        check("R1 eoi", {31'd0, eoi_pulse}, 32'd0);
        bus_read(win(12'h000), rd); check("R1 index", rd, 32'd0);
        bus_read(win(12'h010), rd); check("R1 ident", rd, 32'd0);
        bus_write(win(12'h000), 32'h0000_001A);
        bus_read(win(12'h010), rd); check("R1 entry5 lo", rd, 32'h0001_0000);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_read(win(VECS[i].off), rd);
                check(string'(VECS[i].tag), rd, VECS[i].val);
            end else begin
                bus_write(win(VECS[i].off), VECS[i].val);
            end
        end

        // R10 rdata returns to zero in an idle cycle
        @(negedge clk);
        check("R10 idle", bus_rdata, 32'd0);

        // R9 EOI strobe lasts one cycle and carries the vector
        bus_addr = win(12'h040); bus_wdata = 32'hFFFF_FF5C; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 pulse", {31'd0, eoi_pulse}, 32'd1);
        check("R9 vector", {24'd0, eoi_vector}, 32'h5C);
        @(negedge clk);
        check("R9 pulse end", {31'd0, eoi_pulse}, 32'd0);

        // R2 wrong base: write dropped, read zero
        bus_write({12'hFEC, 8'h3B, 12'h000}, 32'h0000_0022);
        bus_read({12'hFEC, 8'h3B, 12'h000}, rd); check("R2 miss read", rd, 32'd0);
        bus_read(win(12'h000), rd); check("R2 index kept", rd, 32'h0000_0012);
        // R2 wrong fixed prefix
        bus_write({12'hFED, cfg_base, 12'h000}, 32'h0000_0033);
        bus_read(win(12'h000), rd); check("R2 prefix miss", rd, 32'h0000_0012);
        // R2 base moved at run time
        cfg_base = 8'h55;
        bus_write({12'hFEC, 8'h55, 12'h000}, 32'h0000_0000);
        bus_read({12'hFEC, 8'h55, 12'h010}, rd); check("R2 new base", rd, 32'h1234_5678);
        bus_read({12'hFEC, 8'h3A, 12'h010}, rd); check("R2 old base", rd, 32'd0);

        // R1 reset in mid run restores entries and index
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        bus_read(win(12'h000), rd); check("R1 index again", rd, 32'd0);
        bus_write(win(12'h000), 32'h0000_003F);
        bus_read(win(12'h010), rd); check("R1 entry23 hi", rd, 32'd0);
        bus_write(win(12'h000), 32'h0000_003E);
        bus_read(win(12'h010), rd); check("R1 entry23 lo", rd, 32'h0001_0000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule